// File: doc/BRIEF.md
# Dual-Clock Stream Channel

This block is a one-way queue between a single producer and a single consumer. The two sides may run from unrelated clocks. No other agent shares the channel and there is no arbitration. Every stored entry is a data word with one sideband control bit beside it. The word and its bit are accepted together and delivered together.

The producer side uses a valid/ready handshake. A word is taken on a producer clock edge when `in_valid` and `in_ready` are both high. `in_ready` low means the queue is full, and the producer must hold its word until `in_ready` returns. A word offered while `in_ready` is low is not stored.

The consumer side also uses valid/ready. `out_valid` high means at least one entry is waiting, and `out_data`/`out_ctrl` already show the oldest entry (first-word fall-through). The entry is removed on a consumer clock edge when `out_ready` and `out_valid` are both high. `out_ready` has no effect while `out_valid` is low.

Each side sees the other's position through Gray-coded pointers and a chain of synchronizer flops. Because of that chain, `in_ready` and `out_valid` can stay at their cautious value for a few cycles after the other side moves. They never report space or data that is not there.

Top module: `stream_link_fifo`

## Requirements
- R1: After both resets are released, `in_ready` is 1 and `out_valid` is 0.
- R2: Entries leave in the order they were accepted, and each `out_ctrl` bit stays paired with its `out_data` word.
- R3: With 2**ADDR_W entries stored and no reads, `in_ready` is 0. From an empty queue with `in_valid` held high, exactly 2**ADDR_W words are accepted.
- R4: A word offered while `in_ready` is 0 is not stored. After the stored entries are drained, `out_valid` stays 0.
- R5: Raising `out_ready` while `out_valid` is 0 removes nothing. The next word written is the next word read.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_ctrl` and `out_valid` hold, showing the oldest entry.
- R7: With SYNC_STAGES=2, a word written into an empty queue raises `out_valid` within 4 consumer clock cycles.
- R8: With SYNC_STAGES=2, one read from a full queue raises `in_ready` within 5 producer clock cycles.
- R9: Ordering and pairing hold for any ratio between the two clocks and any pattern of stalls on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side reset, asynchronous, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Queue can accept a word (not full) |
| in_data | input | DATA_W | Data word offered |
| in_ctrl | input | 1 | Control bit offered with the word |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side reset, asynchronous, active low |
| out_valid | output | 1 | At least one entry is available |
| out_ready | input | 1 | Consumer takes the shown entry |
| out_data | output | DATA_W | Oldest stored data word |
| out_ctrl | output | 1 | Control bit of the oldest entry |

## Verification
The bench builds the block with ADDR_W=2, DATA_W=32 and SYNC_STAGES=2. With a depth of four, the full condition is reached after a handful of writes, and the pointer MSB wraps many times during the streaming sweeps. The two latency bounds can then be measured as cycle counts. The sweeps run with the consumer clock first slower and then faster than the 100 MHz producer clock, and with deterministic stall patterns on both sides. Every word is computed from its sequence index, so order, pairing and any dropped or duplicated entry show up directly.

// File: rtl/stream_link_pkg.sv
package stream_link_pkg;

  localparam int unsigned PTR_MAX_W = 32;

  function automatic logic [PTR_MAX_W-1:0] bin2gray(logic [PTR_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX_W-1:0] gray2bin(logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/link_gray_sync.sv
module link_gray_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/link_wr_side.sv
module link_wr_side
  import stream_link_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W:0]   rd_gray_sync,
  output logic              ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W:0]   wr_gray
);

  localparam int unsigned P     = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [P-1:0] wr_bin, wr_bin_nx, wr_gray_q;
  logic         full;

  // Full: writer is exactly one lap ahead of the (possibly stale) reader.
  assign full      = (wr_gray_q == {~rd_gray_sync[P-1:P-2], rd_gray_sync[P-3:0]});
  assign wr_en     = push & ~full;
  assign wr_bin_nx = wr_bin + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin    <= '0;
      wr_gray_q <= '0;
    end else if (wr_en) begin
      wr_bin    <= wr_bin_nx;
      wr_gray_q <= P'(bin2gray(PTR_MAX_W'(wr_bin_nx)));
    end
  end

  assign ready   = ~full;
  assign wr_addr = wr_bin[ADDR_W-1:0];
  assign wr_gray = wr_gray_q;

  // Occupancy as seen by the writer (stale reader pointer only overstates it).
  logic [P-1:0] occ_seen;
  assign occ_seen = wr_bin - P'(gray2bin(PTR_MAX_W'(rd_gray_sync)));

  initial assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_seen <= P'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !ready) |=> $stable(wr_bin));

  assert_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_gray_q ^ $past(wr_gray_q)) <= 1);

endmodule

// File: rtl/link_rd_side.sv
module link_rd_side
  import stream_link_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic [ADDR_W:0]   wr_gray_sync,
  output logic              avail,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   rd_gray
);

  localparam int unsigned P     = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [P-1:0] rd_bin, rd_bin_nx, rd_gray_q;
  logic         rd_en;

  assign avail     = (rd_gray_q != wr_gray_sync);
  assign rd_en     = pop & avail;
  assign rd_bin_nx = rd_bin + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin    <= '0;
      rd_gray_q <= '0;
    end else if (rd_en) begin
      rd_bin    <= rd_bin_nx;
      rd_gray_q <= P'(bin2gray(PTR_MAX_W'(rd_bin_nx)));
    end
  end

  assign rd_addr = rd_bin[ADDR_W-1:0];
  assign rd_gray = rd_gray_q;

  logic [P-1:0] occ_seen;
  assign occ_seen = P'(gray2bin(PTR_MAX_W'(wr_gray_sync))) - rd_bin;

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occ_seen <= P'(DEPTH));

  assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !avail) |=> $stable(rd_bin));

  assert_avail_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && !pop) |=> avail);

  assert_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_gray_q ^ $past(rd_gray_q)) <= 1);

endmodule

// File: rtl/link_store.sv
module link_store #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned W      = 33
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/stream_link_fifo.sv
module stream_link_fifo #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ctrl
);

  localparam int unsigned P = ADDR_W + 1;
  localparam int unsigned W = DATA_W + 1;

  logic [P-1:0]      wr_gray, rd_gray, wr_gray_rq, rd_gray_wq;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_en;
  logic [W-1:0]      rd_word;

  link_wr_side #(.ADDR_W(ADDR_W)) wr_side_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .push(in_valid),
    .rd_gray_sync(rd_gray_wq), .ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_gray(wr_gray)
  );

  link_gray_sync #(.W(P), .STAGES(SYNC_STAGES)) rd_to_wr_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_wq)
  );

  link_gray_sync #(.W(P), .STAGES(SYNC_STAGES)) wr_to_rd_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_rq)
  );

  link_rd_side #(.ADDR_W(ADDR_W)) rd_side_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .pop(out_ready),
    .wr_gray_sync(wr_gray_rq), .avail(out_valid),
    .rd_addr(rd_addr), .rd_gray(rd_gray)
  );

  link_store #(.ADDR_W(ADDR_W), .W(W)) store_i (
    .wr_clk(wr_clk), .we(wr_en), .waddr(wr_addr),
    .wdata({in_ctrl, in_data}), .raddr(rd_addr), .rdata(rd_word)
  );

  assign out_data = rd_word[DATA_W-1:0];
  assign out_ctrl = rd_word[DATA_W];

  assert_head_stable_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_ctrl)));

endmodule

// File: tb/stream_link_fifo_tb_top.sv
`timescale 1ns/1ps
module stream_link_fifo_tb_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic in_valid = 0, in_ctrl = 0, out_ready = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_ctrl;
  logic [DATA_W-1:0] out_data;

  real rd_half = 7.0;
  int  checks = 0, errors = 0;
  bit  done = 0;

  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  stream_link_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  function automatic logic [DATA_W-1:0] exp_data(int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic exp_ctrl(int i);
    return (i % 3) == 1;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(int i);
    @(negedge wr_clk);
    in_valid = 1; in_data = exp_data(i); in_ctrl = exp_ctrl(i);
    while (!in_ready) @(negedge wr_clk);
    @(posedge wr_clk);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk); in_valid = 0;
  endtask

  task automatic pop_check(int k, string req);
    @(negedge rd_clk);
    out_ready = 1;
    while (!out_valid) @(negedge rd_clk);
    chk(out_data == exp_data(k) && out_ctrl == exp_ctrl(k), req,
        {31'd0, out_ctrl, out_data}, {31'd0, exp_ctrl(k), exp_data(k)});
    @(posedge rd_clk);
  endtask

  task automatic rd_idle();
    @(negedge rd_clk); out_ready = 0;
  endtask

  task automatic sweep(int base, int n);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          if ((i * 7) % 5 == 0) begin
            @(negedge wr_clk); in_valid = 0;
          end
          push(base + i);
        end
        wr_idle();
      end
      begin
        for (int k = 0; k < n; k++) begin
          if ((k * 3) % 4 == 0) begin
            @(negedge rd_clk); out_ready = 0;
          end
          pop_check(base + k, "R9/R2 stream order");
        end
        rd_idle();
      end
    join
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc, n;
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (2) @(negedge wr_clk);
    // R1 reset state
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);

    // R3 capacity: hold in_valid for DEPTH+4 cycles
    acc = 0;
    for (int c = 0; c < DEPTH + 4; c++) begin
      bit take;
      @(negedge wr_clk);
      in_valid = 1; in_data = exp_data(acc); in_ctrl = exp_ctrl(acc);
      take = in_ready;
      @(posedge wr_clk);
      if (take) acc++;
    end
    chk(acc == DEPTH, "R3 accepted count", acc, DEPTH);
    // R4 offered while full: in_ready stays low
    for (int c = 0; c < 5; c++) begin
      @(negedge wr_clk);
      in_data = 32'hDEAD_0000 + 32'(c);
      chk(in_ready == 0, "R4 in_ready while full", in_ready, 0);
    end
    wr_idle();

    // R2 drain in order, then R4 nothing extra stored
    for (int k = 0; k < DEPTH; k++) pop_check(k, "R2 drain order");
    rd_idle();
    repeat (8) @(negedge rd_clk);
    chk(out_valid == 0, "R4 empty after drain", out_valid, 0);

    // R5 read while empty is ignored
    @(negedge rd_clk); out_ready = 1;
    for (int c = 0; c < 6; c++) begin
      @(negedge rd_clk);
      chk(out_valid == 0, "R5 out_valid idle read", out_valid, 0);
    end
    rd_idle();
    push(4); wr_idle();
    pop_check(4, "R5 next written is next read");
    rd_idle();

    // R6 head stable while stalled
    push(5); push(6); wr_idle();
    @(negedge rd_clk);
    while (!out_valid) @(negedge rd_clk);
    for (int c = 0; c < 6; c++) begin
      @(negedge rd_clk);
      chk(out_valid && out_data == exp_data(5) && out_ctrl == exp_ctrl(5), "R6 head hold",
          {31'd0, out_ctrl, out_data}, {31'd0, exp_ctrl(5), exp_data(5)});
    end
    pop_check(5, "R6 pop head"); pop_check(6, "R6 pop second"); rd_idle();
    repeat (8) @(negedge wr_clk);

    // R7 exists latency
    push(7); wr_idle();
    n = 0;
    while (!out_valid) begin @(negedge rd_clk); n++; end
    chk(n <= 4, "R7 out_valid latency", n, 4);
    pop_check(7, "R7 data"); rd_idle();
    repeat (8) @(negedge wr_clk);

    // R8 ready latency after one read from full
    for (int i = 8; i < 8 + DEPTH; i++) push(i);
    wr_idle();
    repeat (2) @(negedge wr_clk);
    chk(in_ready == 0, "R8 full before read", in_ready, 0);
    pop_check(8, "R8 first"); rd_idle();
    n = 0;
    while (!in_ready) begin @(negedge wr_clk); n++; end
    chk(n <= 5, "R8 in_ready latency", n, 5);
    for (int k = 9; k < 8 + DEPTH; k++) pop_check(k, "R8 drain");
    rd_idle();

    // R9 streaming at two clock ratios
    sweep(100, 120);
    rd_half = 3.0;
    repeat (10) @(negedge rd_clk);
    sweep(300, 120);
    repeat (10) @(negedge rd_clk);
    chk(out_valid == 0, "R9 empty after sweeps", out_valid, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule